// File: doc/BRIEF.md
# Latching Byte-Wide GPIO Port

This block gives a processor access to six byte-wide groups of general purpose I/O lines through a small address/data bus with separate read and write strobes. Offsets 0 to 5 reach one location per group and offset 7 holds a control word. The top two bits of the control word pick which register bank the six group offsets reach: the data registers, the output-enable registers, or one of two read-source select registers. The low six bits of the control word each block processor writes to one group's data register.

Each pin is modelled as a separate input level, output value and output enable. Every group has a strobe input. A falling edge on the strobe captures the group's eight input levels into a latch. When a data register is read, every bit picks its own source from the two select bits for that bit: the live input level, the value the processor last wrote, the latched level, or the latched byte decoded from reflected Gray code to binary. Pin and strobe inputs pass through two-flop synchronisers before use. Read data is registered on the read strobe.

Top module: `gpio_latch_port`

## Requirements
- R1: After reset the control word and all group registers (data, output enable, both select banks, latch) are 0, so pin_out, pin_oe and bus_rdata are all 0.
- R2: The control word at offset 7 can be written and read back whatever bank is selected. Offset 6 ignores writes and reads as 0.
- R3: Control bits [7:6] select the bank seen at offsets 0 to 5: 00 = data registers, 01 = output-enable registers, 10 = low select bank, 11 = high select bank. A write in banks 01, 10 and 11 stores into that bank's register, and a read in those banks returns that register unchanged.
- R4: When control bit n (n = 0 to 5) is 1, a write to offset n in bank 00 leaves that group's data register and pin_out byte unchanged.
- R5: pin_out byte n equals group n's data register, and pin_oe byte n equals group n's output-enable register. A 1 in an enable bit drives the line.
- R6: A data read of a bit whose {high select, low select} bits are 00 returns the synchronised input level, even when that line is enabled as an output with a different value.
- R7: Select bits 01 return the processor-written data register bit, even when it differs from the input level.
- R8: Select bits 10 return the latched bit. The latch for group n takes the synchronised input byte on a falling edge of lat_stb[n] and holds it until the next falling edge. An input change that reaches the pins together with the strobe fall is captured.
- R9: Select bits 11 return the latch decoded from reflected Gray code: bit 7 is passed through, and each lower bit is its latched bit XOR the next-higher decoded bit.
- R10: bus_rdata loads the selected read value on a clock edge where bus_rd is 1, and holds its value otherwise.
- R11: Each of the eight bits of a group picks its read source on its own, so one read can return a mix of the four sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Input levels, byte n for group n |
| pin_out | output | 48 | Output values |
| pin_oe | output | 48 | Output enables |
| lat_stb | input | 6 | Latch strobes, one per group |

## Verification
A strobe falling edge and a change of the input byte can arrive in the same cycle. Both travel through the same two synchroniser stages, so the edge is seen in the same cycle that the new byte appears. The bench drives a new pin pattern and pulls the strobe low at the same clock edge, then checks through a latched-source read that the new byte was captured. Separately it checks that a later pin change leaves the latched view unchanged.

// File: rtl/gpio_latch_pkg.sv
package gpio_latch_pkg;

    // Bank seen at the group offsets, chosen by control bits [7:6]
    typedef enum logic [1:0] {
        BANK_DATA   = 2'b00,
        BANK_OE     = 2'b01,
        BANK_SEL_LO = 2'b10,
        BANK_SEL_HI = 2'b11
    } bank_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/gpio_group.sv
module gpio_group
    import gpio_latch_pkg::*;
#(
    parameter int GRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_e            bank,
    input  logic             wr_en,
    input  logic             wr_block,
    input  logic [GRP_W-1:0] wr_data,
    input  logic [GRP_W-1:0] pin_sync,
    input  logic             stb_sync,
    output logic [GRP_W-1:0] rd_val,
    output logic [GRP_W-1:0] drv_val,
    output logic [GRP_W-1:0] drv_en
);

    typedef struct packed {
        logic [GRP_W-1:0] data;
        logic [GRP_W-1:0] oe;
        logic [GRP_W-1:0] sel_lo;
        logic [GRP_W-1:0] sel_hi;
        logic [GRP_W-1:0] lat;
        logic             stb_prev;
    } grp_t;

    grp_t st_d, st_q;
    logic [GRP_W-1:0] dec;
    logic [GRP_W-1:0] mix;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_sync;
        if (st_q.stb_prev && !stb_sync) st_d.lat = pin_sync;
        if (wr_en) begin
            case (bank)
                BANK_DATA:   if (!wr_block) st_d.data = wr_data;
                BANK_OE:     st_d.oe     = wr_data;
                BANK_SEL_LO: st_d.sel_lo = wr_data;
                BANK_SEL_HI: st_d.sel_hi = wr_data;
                default:     st_d = st_d;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Reflected Gray to binary: each bit is the XOR of itself and all higher bits
    for (genvar i = 0; i < GRP_W; i++) begin : g_dec
        assign dec[i] = ^st_q.lat[GRP_W-1:i];
    end

    always_comb begin
        for (int i = 0; i < GRP_W; i++) begin
            case ({st_q.sel_hi[i], st_q.sel_lo[i]})
                2'b00:   mix[i] = pin_sync[i];
                2'b01:   mix[i] = st_q.data[i];
                2'b10:   mix[i] = st_q.lat[i];
                default: mix[i] = dec[i];
            endcase
        end
    end

    always_comb begin
        case (bank)
            BANK_DATA:   rd_val = mix;
            BANK_OE:     rd_val = st_q.oe;
            BANK_SEL_LO: rd_val = st_q.sel_lo;
            default:     rd_val = st_q.sel_hi;
        endcase
    end

    assign drv_val = st_q.data;
    assign drv_en  = st_q.oe;

    // R4: a blocked data write leaves the driven byte alone
    a_r4_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_block && bank == BANK_DATA) |=> $stable(drv_val));

    // R5: an enable write shows up on the enables next cycle
    a_r5_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank == BANK_OE) |=> (drv_en == $past(wr_data)));

    // R8: a strobe fall captures the synchronised byte
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_sync) |=> (st_q.lat == $past(pin_sync)));

    // R8: no fall, no change of the latch
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.stb_prev && !stb_sync) |=> $stable(st_q.lat));

endmodule

// File: rtl/gpio_latch_port.sv
module gpio_latch_port
    import gpio_latch_pkg::*;
#(
    parameter  int NUM_GRP = 6,   // at most 6: bits 6 and 7 of the control word pick the bank
    parameter  int GRP_W   = 8,
    parameter  int ADDR_W  = 3,
    localparam int PIN_W   = NUM_GRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GRP_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [GRP_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    input  logic [NUM_GRP-1:0] lat_stb
);

    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(7);

    typedef struct packed {
        logic [GRP_W-1:0] ctrl;
        logic [GRP_W-1:0] rd;
    } top_t;

    top_t st_d, st_q;

    logic [PIN_W-1:0]   pin_s;
    logic [NUM_GRP-1:0] stb_s;
    logic [GRP_W-1:0]   grp_rd [NUM_GRP];
    logic [GRP_W-1:0]   rd_sel;
    bank_e              bank;

    assign bank = bank_e'(st_q.ctrl[7:6]);

    gpio_sync #(.W(PIN_W + NUM_GRP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lat_stb, pin_in}),
        .q     ({stb_s, pin_s})
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        gpio_group #(.GRP_W(GRP_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .bank     (bank),
            .wr_en    (bus_wr && bus_addr == ADDR_W'(g)),
            .wr_block (st_q.ctrl[g]),
            .wr_data  (bus_wdata),
            .pin_sync (pin_s[g*GRP_W +: GRP_W]),
            .stb_sync (stb_s[g]),
            .rd_val   (grp_rd[g]),
            .drv_val  (pin_out[g*GRP_W +: GRP_W]),
            .drv_en   (pin_oe[g*GRP_W +: GRP_W])
        );
    end

    always_comb begin
        rd_sel = '0;
        if (bus_addr == CTRL_OFS) rd_sel = st_q.ctrl;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (bus_addr == ADDR_W'(g)) rd_sel = grp_rd[g];
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == CTRL_OFS) st_d.ctrl = bus_wdata;
        if (bus_rd) st_d.rd = rd_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rd;

    // R2: the control word takes every write at its offset
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_OFS) |=> (st_q.ctrl == $past(bus_wdata)));

    // R2: the unused offset reads as zero
    a_r2_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(6)) |=> (bus_rdata == '0));

    // R10: read data holds without a read strobe
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/gpio_latch_port_test.sv
module gpio_latch_port_test;

    localparam int NG = 6;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic [47:0]   pin_in = '0;
    logic [47:0]   pin_out;
    logic [47:0]   pin_oe;
    logic [5:0]    lat_stb = '1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_ctrl;
    logic [7:0] m_data [NG];
    logic [7:0] m_oe   [NG];
    logic [7:0] m_s2   [NG];
    logic [7:0] m_s3   [NG];
    logic [7:0] m_lat  [NG];

    always #2 clk = ~clk;   // 250 MHz

    gpio_latch_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .lat_stb(lat_stb)
    );

    function automatic logic [7:0] gray_dec(input logic [7:0] g);
        logic [7:0] b;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) b[i] = g[i] ^ b[i+1];
        return b;
    endfunction

    function automatic logic [7:0] exp_read(input int ofs);
        logic [7:0] r;
        logic [7:0] pins;
        if (ofs == 7) return m_ctrl;
        if (ofs == 6) return 8'h00;
        case (m_ctrl[7:6])
            2'b01: return m_oe[ofs];
            2'b10: return m_s2[ofs];
            2'b11: return m_s3[ofs];
            default: ;
        endcase
        pins = pin_in[ofs*8 +: 8];
        for (int i = 0; i < 8; i++) begin
            case ({m_s3[ofs][i], m_s2[ofs][i]})
                2'b00:   r[i] = pins[i];
                2'b01:   r[i] = m_data[ofs][i];
                2'b10:   r[i] = m_lat[ofs][i];
                default: r[i] = gray_dec(m_lat[ofs])[i];
            endcase
        end
        return r;
    endfunction

    function automatic logic [47:0] cat(input int which);
        logic [47:0] v;
        for (int g = 0; g < NG; g++) v[g*8 +: 8] = (which == 0) ? m_data[g] : m_oe[g];
        return v;
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int ofs, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 3'(ofs); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (ofs == 7) m_ctrl = d;
        else if (ofs < 6) begin
            case (m_ctrl[7:6])
                2'b00: if (!m_ctrl[ofs]) m_data[ofs] = d;
                2'b01: m_oe[ofs] = d;
                2'b10: m_s2[ofs] = d;
                default: m_s3[ofs] = d;
            endcase
        end
    endtask

    task automatic bus_read_check(input int ofs, input string req);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = 3'(ofs); bus_rd = 1'b1;
        e = exp_read(ofs);
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, {40'h0, bus_rdata}, {40'h0, e});
    endtask

    task automatic set_pins(input logic [47:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe(input int g);
        @(negedge clk);
        lat_stb[g] = 1'b0;
        repeat (4) @(negedge clk);
        m_lat[g] = pin_in[g*8 +: 8];
        lat_stb[g] = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        check(req, pin_out, cat(0));
        check(req, pin_oe, cat(1));
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        m_ctrl = '0;
        for (int g = 0; g < NG; g++) begin
            m_data[g] = '0; m_oe[g] = '0; m_s2[g] = '0; m_s3[g] = '0; m_lat[g] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 rdata", {40'h0, bus_rdata}, '0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read_check(7, "R1 ctrl");
        bus_read_check(2, "R1 data");

        // R2: control word in every bank, hole at 6
        bus_write(7, 8'hC5); bus_read_check(7, "R2 ctrl bank11");
        bus_write(6, 8'hFF); bus_read_check(6, "R2 hole");
        bus_write(7, 8'h00);

        // R5 / R7 / R6: drive data and enables, read written and pin views
        bus_write(0, 8'hA5);
        bus_write(7, 8'h40); bus_write(0, 8'hFF);  // enables
        bus_read_check(0, "R3 oe bank");
        bus_write(7, 8'h80); bus_write(0, 8'hFF);  // low select: written value
        bus_read_check(0, "R3 sel_lo bank");
        bus_write(7, 8'h00);
        check_outs("R5");
        set_pins(48'h0000_0000_003C);
        bus_read_check(0, "R7 written view");
        bus_write(7, 8'h80); bus_write(0, 8'h00); bus_write(7, 8'h00);
        bus_read_check(0, "R6 pin view while driven");

        // R4: blocked write
        bus_write(7, 8'h01);
        bus_write(0, 8'h12);
        check_outs("R4 blocked");
        bus_write(7, 8'h00);
        bus_write(0, 8'h34);
        check_outs("R4 unblocked");

        // R8: pin change and strobe fall in the same cycle
        bus_write(7, 8'hC0); bus_write(1, 8'hFF); bus_write(7, 8'h00);   // latched view
        @(negedge clk);
        pin_in[15:8] = 8'h96; lat_stb[1] = 1'b0;
        repeat (4) @(negedge clk);
        m_lat[1] = 8'h96; lat_stb[1] = 1'b1;
        repeat (3) @(negedge clk);
        bus_read_check(1, "R8 simultaneous capture");
        set_pins({pin_in[47:16], 8'h11, pin_in[7:0]});
        bus_read_check(1, "R8 latch holds");

        // R9: Gray decode
        bus_write(7, 8'h80); bus_write(1, 8'hFF); bus_write(7, 8'h00);
        bus_read_check(1, "R9 gray");
        set_pins({pin_in[47:16], 8'h80, pin_in[7:0]});
        strobe(1);
        bus_read_check(1, "R9 gray 0x80");
        check("R9 gray 0x80 value", {40'h0, bus_rdata}, {40'h0, 8'hFF});

        // R11: mixed sources in one read
        bus_write(7, 8'hC0); bus_write(1, 8'hF0);
        bus_write(7, 8'h80); bus_write(1, 8'hCC);
        bus_write(7, 8'h00); bus_write(1, 8'h5A);
        bus_read_check(1, "R11 mixed");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0: bus_write(7, 8'($urandom));
                1, 2: bus_write($urandom_range(0, 6), 8'($urandom));
                3: set_pins({$urandom, 16'($urandom)});
                4: strobe($urandom_range(0, 5));
                default: bus_read_check($urandom_range(0, 7), "R3 R10 random read");
            endcase
            check_outs("R5 random");
        end

        // R10: hold without read strobe
        bus_read_check(7, "R10 read");
        bus_write(7, 8'h3C);
        repeat (2) @(negedge clk);
        check("R10 hold", {40'h0, bus_rdata}, {40'h0, exp_read_prev()});
        done = 1'b1;
    end

    logic [7:0] last_rd;
    always @(negedge clk) if (bus_rd) last_rd <= exp_read(int'(bus_addr));

    function automatic logic [7:0] exp_read_prev();
        return last_rd;
    endfunction

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule